// File: doc/BRIEF.md
# Four-Level BCD Operand Stack

This block holds the word-wide operand registers of a decimal calculator datapath. Level 0 is the working register C. Levels 1 to 3 form the operand stack behind it, called D, E and F here. Each level is one full word of fourteen 4-bit digits, which is 56 bits, and every transfer moves the whole word. Sign digits and exponent digits move with the mantissa, and no field select is applied.

Four stack commands are accepted:

- **Push** copies C into the stack and leaves C unchanged.
- **Pop** delivers D to the external A register through a write strobe, and the stack closes up behind it.
- **Rotate-down** cycles C through all four levels.
- **Clear** zeroes every level and the A register.

A separate load port lets the surrounding arithmetic unit write a new word into C. Only one operation takes effect per clock, chosen by a fixed priority.

The arithmetic on A and C is done outside the block. The block supplies only the word moves. Every level is visible at the output so the datapath can read C and the stack contents directly.

Top module: `bcd_opstack`

## Requirements
- R1: Push moves C into D, D into E and E into F, and leaves C unchanged. The new contents are visible after the clock edge that accepts the command.
- R2: Pop sets `a_o` to the old D and raises `a_we_o` for one cycle. It also moves E into D and F into E. F keeps its value, so the top entry is duplicated, and C is unchanged.
- R3: Rotate-down moves D into C, E into D and F into E, and the old C into F.
- R4: Clear sets all four levels and `a_o` to zero, and raises `a_we_o` for one cycle so that the external A register is cleared too.
- R5: When several commands are raised in one cycle, only the one with the highest priority takes effect. The order is clear, then push, then pop, then rotate-down, then load.
- R6: When `c_ld_i` is high and no stack command is raised, C takes the value of `c_din_i` and D, E and F are unchanged.
- R7: Every move carries all 56 bits. Each of the fourteen 4-bit digits arrives at the same position, sign digits included. Word C occupies bits 55:0 of `lvl_o`, D bits 111:56, E bits 167:112 and F bits 223:168.
- R8: While `rst_n` is low at a clock edge, all levels and `a_o` become zero and `a_we_o` becomes low, whatever the command inputs are.
- R9: In a cycle with no pop and no clear, `a_we_o` stays low and `a_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Clear all levels and A |
| push_i | input | 1 | Push C into the stack |
| pop_i | input | 1 | Pop D into A |
| rot_i | input | 1 | Rotate C, D, E, F downward |
| c_ld_i | input | 1 | Load `c_din_i` into C |
| c_din_i | input | 56 | Word to load into C |
| lvl_o | output | 224 | All levels, C in the lowest 56 bits and F in the highest |
| a_o | output | 56 | Word destined for register A |
| a_we_o | output | 1 | One-cycle strobe: write `a_o` into A |

## Verification
Every result of this block is registered once, so the level contents, `a_o` and `a_we_o` all reflect a command one rising edge after it is presented. The strobe then drops on the following edge unless another pop or clear follows. The bench changes the command inputs on a falling edge and compares all outputs on the next falling edge. Exactly one rising edge separates stimulus and sample, and the comparison happens away from the edge that updates the registers. Idle vectors sampled the same way confirm that the strobe falls back and that `a_o` holds.

// File: rtl/opstk_pkg.sv
// Package: shared types for the operand stack.
// Holds the single decoded operation that the arbiter hands to every level.
package opstk_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_CLR  = 3'd1,
        OP_PUSH = 3'd2,
        OP_POP  = 3'd3,
        OP_ROT  = 3'd4,
        OP_LOAD = 3'd5
    } stk_op_e;

endpackage

// File: rtl/opstk_cmd_arb.sv
// Module: opstk_cmd_arb
// Reduces the raw command strobes to one operation per clock.
// Fixed priority: clear, push, pop, rotate, load.
// Assumes the strobes are synchronous to clk. The output is combinational.
module opstk_cmd_arb
    import opstk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr_i,
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    rot_i,
    input  logic    ld_i,
    output stk_op_e op_o
);

    // Pick the single winning operation by priority.
    always_comb begin
        if (clr_i)       op_o = OP_CLR;
        else if (push_i) op_o = OP_PUSH;
        else if (pop_i)  op_o = OP_POP;
        else if (rot_i)  op_o = OP_ROT;
        else if (ld_i)   op_o = OP_LOAD;
        else             op_o = OP_IDLE;
    end

    // R5: a pop is granted only when no higher-priority command is raised
    p_pop_yields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_POP) |-> (!clr_i && !push_i));

    // R5: a load is granted only when no stack command is raised
    p_load_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_LOAD) |-> (!clr_i && !push_i && !pop_i && !rot_i));

endmodule

// File: rtl/opstk_level.sv
// Module: opstk_level
// One word-wide stack level.
// Next value comes from the level below (push), the level above (pop and
// rotate), level 0 (rotate wrap, top level only) or the load port (bottom
// level only).
// Assumes its neighbours are connected by the parent; unused neighbours are tied to zero.
module opstk_level
    import opstk_pkg::*;
#(
    parameter int W         = 56,
    parameter bit IS_BOTTOM = 1'b0,
    parameter bit IS_TOP    = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stk_op_e      op_i,
    input  logic [W-1:0] below_i,
    input  logic [W-1:0] above_i,
    input  logic [W-1:0] wrap_i,
    input  logic [W-1:0] load_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] nxt;

    // Choose this level's next word for the granted operation.
    always_comb begin
        nxt = q_o;
        case (op_i)
            OP_CLR:  nxt = '0;
            OP_PUSH: nxt = IS_BOTTOM ? q_o : below_i;
            OP_POP:  nxt = (IS_BOTTOM || IS_TOP) ? q_o : above_i;
            OP_ROT:  nxt = IS_TOP ? wrap_i : above_i;
            OP_LOAD: nxt = IS_BOTTOM ? load_i : q_o;
            default: nxt = q_o;
        endcase
    end

    // Hold the word; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end

    // R4: clear leaves this level at zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLR) |=> (q_o == '0));

    // R9: idle leaves this level untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_IDLE) |=> $stable(q_o));

endmodule

// File: rtl/opstk_pop_port.sv
// Module: opstk_pop_port
// Drives the word and write strobe toward the external A register.
// Pop delivers D; clear delivers zero. Both pulse the strobe for one cycle.
// Assumes A captures a_o on the edge after a_we_o is seen high.
module opstk_pop_port
    import opstk_pkg::*;
#(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stk_op_e      op_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] a_o,
    output logic         a_we_o
);

    // Register the outgoing word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o    <= '0;
            a_we_o <= 1'b0;
        end else if (op_i == OP_CLR) begin
            a_o    <= '0;
            a_we_o <= 1'b1;
        end else if (op_i == OP_POP) begin
            a_o    <= d_i;
            a_we_o <= 1'b1;
        end else begin
            a_we_o <= 1'b0;
        end
    end

    // R2: a pop delivers the previous D with the strobe raised
    p_pop_delivers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP) |=> (a_we_o && a_o == $past(d_i)));

    // R9: without pop or clear the strobe drops and the word holds
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_POP && op_i != OP_CLR) |=> (!a_we_o && $stable(a_o)));

endmodule

// File: rtl/bcd_opstack.sv
// Module: bcd_opstack
// Operand stack of LEVELS words, DIGITS 4-bit digits each.
// Level 0 is the working register C; higher levels are D, E, F.
// Provides push, pop-to-A, rotate-down, clear and load-C, one per clock.
// Assumes LEVELS >= 3, so that bottom, middle and top levels all exist.
module bcd_opstack
    import opstk_pkg::*;
#(
    parameter int DIGITS = 14,
    parameter int LEVELS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          push_i,
    input  logic                          pop_i,
    input  logic                          rot_i,
    input  logic                          c_ld_i,
    input  logic [DIGITS*DIGIT_W-1:0]     c_din_i,
    output logic [LEVELS*DIGITS*DIGIT_W-1:0] lvl_o,
    output logic [DIGITS*DIGIT_W-1:0]     a_o,
    output logic                          a_we_o
);

    localparam int W   = DIGITS * DIGIT_W;
    localparam int TOP = LEVELS - 1;

    stk_op_e      op;
    logic [W-1:0] lvl     [LEVELS];
    logic [W-1:0] below_w [LEVELS];
    logic [W-1:0] above_w [LEVELS];

    opstk_cmd_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .push_i (push_i),
        .pop_i  (pop_i),
        .rot_i  (rot_i),
        .ld_i   (c_ld_i),
        .op_o   (op)
    );

    // Build the chain of levels with their neighbour links.
    for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
        if (i == 0) begin : g_bot
            assign below_w[i] = '0;
        end else begin : g_mid_lo
            assign below_w[i] = lvl[i-1];
        end

        if (i == TOP) begin : g_top
            assign above_w[i] = '0;
        end else begin : g_mid_hi
            assign above_w[i] = lvl[i+1];
        end

        opstk_level #(
            .W         (W),
            .IS_BOTTOM (i == 0),
            .IS_TOP    (i == TOP)
        ) u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op),
            .below_i (below_w[i]),
            .above_i (above_w[i]),
            .wrap_i  (lvl[0]),
            .load_i  (c_din_i),
            .q_o     (lvl[i])
        );

        assign lvl_o[i*W +: W] = lvl[i];
    end

    opstk_pop_port #(.W(W)) u_pop (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .d_i    (lvl[1]),
        .a_o    (a_o),
        .a_we_o (a_we_o)
    );

    // R1: push copies C into D and leaves C unchanged
    p_push_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |=> (lvl[1] == $past(lvl[0]) && lvl[0] == $past(lvl[0])
                              && lvl[TOP] == $past(lvl[TOP-1])));

    // R2: pop keeps C and duplicates the top entry
    p_pop_dup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP) |=> (lvl[0] == $past(lvl[0]) && lvl[TOP] == $past(lvl[TOP])
                             && lvl[TOP-1] == $past(lvl[TOP])));

    // R3: rotate-down wraps the old C into the top level
    p_rot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROT) |=> (lvl[0] == $past(lvl[1]) && lvl[TOP] == $past(lvl[0])));

    // R6: a load touches C only
    p_load_c_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (lvl[0] == $past(c_din_i) && lvl[1] == $past(lvl[1])));

endmodule

// File: tb/bcd_opstack_test.sv
module bcd_opstack_test;

    localparam int DIGITS = 14;
    localparam int LEVELS = 4;
    localparam int W      = DIGITS * 4;
    localparam int NVEC   = 18;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  clr_i, push_i, pop_i, rot_i, c_ld_i;
    logic [W-1:0]          c_din_i;
    logic [LEVELS*W-1:0]   lvl_o;
    logic [W-1:0]          a_o;
    logic                  a_we_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bcd_opstack #(.DIGITS(DIGITS), .LEVELS(LEVELS)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .rot_i   (rot_i),
        .c_ld_i  (c_ld_i),
        .c_din_i (c_din_i),
        .lvl_o   (lvl_o),
        .a_o     (a_o),
        .a_we_o  (a_we_o)
    );

    // Vector fields: [31:27] cmd {clr,push,pop,rot,ld}, [26:23] load digit,
    // [22:19] C, [18:15] D, [14:11] E, [10:7] F, [6] strobe, [5:2] A digit.
    // Each level digit stands for a word with that digit in all 14 positions.
    localparam logic [31:0] VEC [NVEC] = '{
        {5'b00001, 4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 2'b00},
        {5'b01000, 4'h0, 4'h1, 4'h1, 4'h0, 4'h0, 1'b0, 4'h0, 2'b00},
        {5'b00001, 4'h2, 4'h2, 4'h1, 4'h0, 4'h0, 1'b0, 4'h0, 2'b00},
        {5'b01000, 4'h0, 4'h2, 4'h2, 4'h1, 4'h0, 1'b0, 4'h0, 2'b00},
        {5'b00001, 4'h3, 4'h3, 4'h2, 4'h1, 4'h0, 1'b0, 4'h0, 2'b00},
        {5'b01000, 4'h0, 4'h3, 4'h3, 4'h2, 4'h1, 1'b0, 4'h0, 2'b00},
        {5'b00001, 4'h4, 4'h4, 4'h3, 4'h2, 4'h1, 1'b0, 4'h0, 2'b00},
        {5'b00010, 4'h0, 4'h3, 4'h2, 4'h1, 4'h4, 1'b0, 4'h0, 2'b00},
        {5'b00010, 4'h0, 4'h2, 4'h1, 4'h4, 4'h3, 1'b0, 4'h0, 2'b00},
        {5'b00100, 4'h0, 4'h2, 4'h4, 4'h3, 4'h3, 1'b1, 4'h1, 2'b00},
        {5'b00000, 4'h0, 4'h2, 4'h4, 4'h3, 4'h3, 1'b0, 4'h1, 2'b00},
        {5'b01110, 4'h0, 4'h2, 4'h2, 4'h4, 4'h3, 1'b0, 4'h1, 2'b00},
        {5'b00110, 4'h0, 4'h2, 4'h4, 4'h3, 4'h3, 1'b1, 4'h2, 2'b00},
        {5'b00011, 4'h9, 4'h4, 4'h3, 4'h3, 4'h2, 1'b0, 4'h2, 2'b00},
        {5'b00001, 4'h9, 4'h9, 4'h3, 4'h3, 4'h2, 1'b0, 4'h2, 2'b00},
        {5'b11100, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 2'b00},
        {5'b00001, 4'h5, 4'h5, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 2'b00},
        {5'b00100, 4'h0, 4'h5, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 2'b00}
    };

    function automatic logic [W-1:0] rep(input logic [3:0] d);
        return {DIGITS{d}};
    endfunction

    function automatic string tag_of(input logic [4:0] c);
        if (c[4])                         return "R4";
        if (c[3]) return (c[2:0] != 3'b0) ? "R5" : "R1";
        if (c[2]) return (c[1:0] != 2'b0) ? "R5" : "R2";
        if (c[1]) return c[0] ? "R5" : "R3";
        if (c[0])                         return "R6";
        return "R9";
    endfunction

    // Drive one command set on the falling edge.
    task automatic drive(input logic [4:0] c, input logic [W-1:0] din);
        {clr_i, push_i, pop_i, rot_i, c_ld_i} = c;
        c_din_i = din;
    endtask

    // Compare all outputs against expected words.
    task automatic check_state(input string tag, input logic [W-1:0] ec, ed, ee, ef,
                               input logic ewe, input logic [W-1:0] ea);
        logic [W-1:0] ac, ad, ae, af;
        ac = lvl_o[0*W +: W];
        ad = lvl_o[1*W +: W];
        ae = lvl_o[2*W +: W];
        af = lvl_o[3*W +: W];
        n_chk++;
        if (ac !== ec || ad !== ed || ae !== ee || af !== ef || a_we_o !== ewe || a_o !== ea) begin
            n_err++;
            $display("FAIL %s: got C=%h D=%h E=%h F=%h we=%b A=%h exp C=%h D=%h E=%h F=%h we=%b A=%h",
                     tag, ac, ad, ae, af, a_we_o, a_o, ec, ed, ee, ef, ewe, ea);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] wx, wy;
        wx = 56'h98765432101903;
        wy = 56'h01357924680042;
        rst_n = 1'b0;
        drive(5'b01111, rep(4'h7));
        @(negedge clk);
        @(negedge clk);
        // R8: reset state, with commands raised
        check_state("R8", '0, '0, '0, '0, 1'b0, '0);
        rst_n = 1'b1;
        drive(5'b00000, '0);
        @(negedge clk);

        // Table walk: each vector is sampled one rising edge later.
        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][31:27], rep(VEC[k][26:23]));
            @(negedge clk);
            check_state(tag_of(VEC[k][31:27]), rep(VEC[k][22:19]), rep(VEC[k][18:15]),
                        rep(VEC[k][14:11]), rep(VEC[k][10:7]), VEC[k][6], rep(VEC[k][5:2]));
        end

        // R9: idle after a pop, strobe drops and A holds
        drive(5'b00000, '0);
        @(negedge clk);
        check_state("R9", rep(4'h5), '0, '0, '0, 1'b0, '0);

        // R7: distinct digits across the word, sign positions included
        drive(5'b00001, wx);
        @(negedge clk);
        check_state("R7", wx, '0, '0, '0, 1'b0, '0);
        drive(5'b01000, '0);
        @(negedge clk);
        check_state("R7", wx, wx, '0, '0, 1'b0, '0);
        drive(5'b00001, wy);
        @(negedge clk);
        drive(5'b00010, '0);
        @(negedge clk);
        check_state("R7", wx, '0, '0, wy, 1'b0, '0);
        drive(5'b01000, '0);
        @(negedge clk);
        check_state("R7", wx, wx, '0, '0, 1'b0, '0);
        drive(5'b00100, '0);
        @(negedge clk);
        check_state("R7", wx, '0, '0, '0, 1'b1, wx);

        // R2: top duplicates on pop with a full-width word
        drive(5'b00010, '0);
        @(negedge clk);
        check_state("R3", '0, '0, '0, wx, 1'b0, wx);
        drive(5'b00100, '0);
        @(negedge clk);
        check_state("R2", '0, '0, wx, wx, 1'b1, '0);

        // R8: mid-run reset wins over a push
        drive(5'b01000, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check_state("R8", '0, '0, '0, '0, 1'b0, '0);
        rst_n = 1'b1;
        drive(5'b00000, '0);
        @(negedge clk);
        check_state("R9", '0, '0, '0, '0, 1'b0, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule